// File: doc/BRIEF.md
# Configurable SPI Master Controller

This block is a single-lane SPI master with small transmit and receive word queues and a shift engine. A 10-bit control register configures it while it runs. The register sets the idle clock level, the sampling phase, the bit order, the master role, the system enable, an internal loopback path, manual or automatic slave-select driving, and a transfer inhibit. It also holds two strobe bits that empty the queues and clear themselves one clock cycle later. A plain register port with write and read strobes stands in for a full bus. Software places words into the transmit queue and collects the words returned by the slave from the receive queue.

The serial clock runs at the system clock divided by a fixed even parameter `DIV`. In automatic mode the engine pulls the selected slave-select lines low half a serial period before the first clock edge. It keeps them low while queued words follow back to back, and releases them after the last word. In manual mode the slave-select outputs follow the select register whenever the block is an enabled master.

Register port: address 0 is the control register. Address 1 is the data port: a write pushes a transmit word and a read pops a received word. Address 2 is the slave-select register, whose bits are active-low and reset to all ones.

Top module: `spi_cfg_master`

## Requirements
- R1: The control register at address 0 holds, from bit 0 up: loopback, system enable, master, clock polarity, clock phase, transmit flush, receive flush, manual select, transfer inhibit, LSB-first. Bits 31:10 read 0, and writes to them are ignored.
- R2: After reset, the control register reads 0x180 (inhibit and manual select set), `ss_n` is all ones, `sck` is low and the receive queue reads as empty.
- R3: While no transfer runs, `sck` rests at the clock polarity bit (bit 3): low for 0, high for 1. Every transfer also ends at that level.
- R4: Each transfer moves 8 bits in both directions. With the phase bit (bit 4) at 0, data is sampled on the first edge of each bit period and changed on the second. With it at 1, data is changed on the first edge and sampled on the second.
- R5: With bit 9 at 1, words go out and come in least significant bit first. With bit 9 at 0, they go most significant bit first.
- R6: While the inhibit bit (bit 8) is 1, no transfer starts. Setting it during a transfer stops the transfer on the next clock: `sck` returns to idle, automatic slave select goes high, and the unfinished word is discarded.
- R7: With manual select (bit 7), system enable (bit 1) and master (bit 2) all at 1, `ss_n` equals the select register (address 2). With system enable or master at 0, `ss_n` is all ones.
- R8: In automatic mode, the lines that hold 0 in the select register go low when a transfer starts. The first `sck` edge follows exactly `DIV/2` clocks later. The lines stay low across back-to-back words, so a burst produces a single rise.
- R9: Writing 1 to bit 5 empties the transmit queue, and writing 1 to bit 6 empties the receive queue. Each of these bits reads back 0 from the following clock on.
- R10: With loopback (bit 0) and master set, every received word equals the word sent, whatever `miso` carries.
- R11: One `sck` period lasts exactly `DIV` system clocks.
- R12: A write to address 1 pushes `reg_wdata[7:0]` into the transmit queue. A read of address 1 returns bit 8 set with the oldest received word in bits 7:0 and pops that word, or returns 0 when the receive queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (pops the receive queue at address 1) |
| reg_addr | input | 2 | Register address: 0 control, 1 data, 2 slave select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the current address |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NSS | Active-low slave-select lines |

## Verification
The bench models a slave that samples `mosi` and drives `miso` according to the configured phase and bit order. It runs random words and modes against this model. A design that sampled on the wrong edge, or reversed the order of only one direction, would return words with shifted or mirrored bits. Timing checks measure the gap from slave-select fall to the first edge, and the serial period. A wrong lead time or divider shows up there as an off-by-one count. A burst of several words must raise slave select only once. The directed cases cover the following:
- An inhibit set in the middle of a word must stop the clock and release slave select on the next cycle. A design that finished the word anyway would leave data in the receive queue.
- A flush strobe must empty a loaded queue and then read back 0. A design with a sticky strobe or a missed flush would still send, or still return, the stale words.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;

    localparam int WORD_W = 8;
    localparam int CTRL_W = 10;
    localparam logic [CTRL_W-1:0] CTRL_RST_BITS = 10'h180;

    // control register, bit 9 down to bit 0
    typedef struct packed {
        logic lsb_first;
        logic inhibit;
        logic manual_ss;
        logic rx_flush;
        logic tx_flush;
        logic cpha;
        logic cpol;
        logic master;
        logic spe;
        logic loop;
    } ctrl_t;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_DATA = 2'd1,
        REG_SEL  = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic {
        ENG_IDLE,
        ENG_RUN
    } eng_state_e;

    function automatic logic [WORD_W-1:0] flip_word(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        for (int i = 0; i < WORD_W; i++) begin
            r[i] = w[WORD_W-1-i];
        end
        return r;
    endfunction

    // the engine always shifts from the top bit; LSB-first is a mirror
    function automatic logic [WORD_W-1:0] order_word(input logic [WORD_W-1:0] w,
                                                     input logic lsb);
        return lsb ? flip_word(w) : w;
    endfunction

endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            if (do_push && !do_pop)      count <= count + CW'(1);
            else if (do_pop && !do_push) count <= count - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush |=> empty); // R9

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !flush) |=> (full && count == $past(count))); // R12

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_ctl_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              lsb_first,
    input  logic              loop_en,
    input  logic              tx_empty,
    input  logic [WORD_W-1:0] tx_data,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_data,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic              busy
);
    localparam int HALF  = DIV / 2;
    localparam int CW    = $clog2(HALF) + 1;
    localparam int EDGES = 2 * WORD_W;
    localparam int EW    = $clog2(EDGES + 1);

    eng_state_e        state;
    logic [CW-1:0]     cnt;
    logic [EW-1:0]     edge_idx;
    logic [WORD_W-1:0] tx_sr, rx_sr;
    logic              sck_q;
    logic              tick, last_phase, sample_edge, change_edge, serial_in, start;

    assign busy        = (state == ENG_RUN);
    assign tick        = (cnt == CW'(HALF - 1));
    assign last_phase  = (edge_idx == EW'(EDGES));
    // even edge index = first edge of a bit period
    assign sample_edge = cpha ? edge_idx[0] : !edge_idx[0];
    assign change_edge = cpha ? (!edge_idx[0] && edge_idx != '0) : edge_idx[0];
    assign serial_in   = loop_en ? tx_sr[WORD_W-1] : miso;
    assign start       = (state == ENG_IDLE) && en && !tx_empty;
    assign rx_push     = busy && en && tick && last_phase;
    assign tx_pop      = start || (rx_push && !tx_empty);
    assign rx_data     = order_word(rx_sr, lsb_first);
    assign sck         = busy ? sck_q : cpol;
    assign mosi        = tx_sr[WORD_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ENG_IDLE;
            cnt      <= '0;
            edge_idx <= '0;
            tx_sr    <= '0;
            rx_sr    <= '0;
            sck_q    <= 1'b0;
        end else begin
            unique case (state)
                ENG_IDLE: begin
                    sck_q    <= cpol;
                    cnt      <= '0;
                    edge_idx <= '0;
                    if (start) begin
                        tx_sr <= order_word(tx_data, lsb_first);
                        state <= ENG_RUN;
                    end
                end
                ENG_RUN: begin
                    if (!en) begin
                        state <= ENG_IDLE;
                        sck_q <= cpol;
                    end else if (!tick) begin
                        cnt <= cnt + CW'(1);
                    end else begin
                        cnt <= '0;
                        if (last_phase) begin
                            edge_idx <= '0;
                            if (!tx_empty) tx_sr <= order_word(tx_data, lsb_first);
                            else           state <= ENG_IDLE;
                        end else begin
                            sck_q    <= ~sck_q;
                            edge_idx <= edge_idx + EW'(1);
                            if (sample_edge) rx_sr <= {rx_sr[WORD_W-2:0], serial_in};
                            if (change_edge) tx_sr <= {tx_sr[WORD_W-2:0], 1'b0};
                        end
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    AST_INHIBIT_STOPS: assert property (@(posedge clk) disable iff (rst)
        !en |=> !busy); // R6

    AST_SCK_RESTS: assert property (@(posedge clk) disable iff (rst)
        (busy && last_phase) |-> (sck_q == cpol)); // R3

    AST_EDGE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (busy && en && tick && !last_phase) |=> (sck_q != $past(sck_q))); // R11

endmodule

// File: rtl/spi_cfg_master.sv
module spi_cfg_master
    import spi_ctl_pkg::*;
#(
    parameter int DIV        = 4,
    parameter int NSS        = 4,
    parameter int FIFO_DEPTH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           reg_we,
    input  logic           reg_re,
    input  logic [1:0]     reg_addr,
    input  logic [31:0]    reg_wdata,
    output logic [31:0]    reg_rdata,
    output logic           sck,
    output logic           mosi,
    input  logic           miso,
    output logic [NSS-1:0] ss_n
);
    ctrl_t             ctrl_q;
    logic [NSS-1:0]    sel_q;
    reg_sel_e          addr_e;
    logic              wr_ctrl, wr_data, wr_sel, rd_data;
    logic              tx_empty, rx_empty, tx_full_unused, rx_full_unused;
    logic [WORD_W-1:0] tx_head, rx_head, rx_word;
    logic              tx_pop, rx_push, eng_busy, eng_en, loop_en, ss_live;
    logic              unused_hi;

    assign addr_e    = reg_sel_e'(reg_addr);
    assign wr_ctrl   = reg_we && (addr_e == REG_CTRL);
    assign wr_data   = reg_we && (addr_e == REG_DATA);
    assign wr_sel    = reg_we && (addr_e == REG_SEL);
    assign rd_data   = reg_re && (addr_e == REG_DATA);
    assign unused_hi = ^reg_wdata[31:CTRL_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= ctrl_t'(CTRL_RST_BITS);
            sel_q  <= '1;
        end else begin
            if (wr_ctrl) begin
                ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
            end else begin
                ctrl_q.tx_flush <= 1'b0;
                ctrl_q.rx_flush <= 1'b0;
            end
            if (wr_sel) sel_q <= reg_wdata[NSS-1:0];
        end
    end

    assign eng_en  = ctrl_q.spe && ctrl_q.master && !ctrl_q.inhibit;
    assign loop_en = ctrl_q.loop && ctrl_q.master;
    assign ss_live = ctrl_q.spe && ctrl_q.master;

    spi_word_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst(rst), .flush(ctrl_q.tx_flush),
        .push(wr_data), .wdata(reg_wdata[WORD_W-1:0]),
        .pop(tx_pop), .rdata(tx_head),
        .empty(tx_empty), .full(tx_full_unused)
    );

    spi_word_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .flush(ctrl_q.rx_flush),
        .push(rx_push), .wdata(rx_word),
        .pop(rd_data), .rdata(rx_head),
        .empty(rx_empty), .full(rx_full_unused)
    );

    spi_shift_engine #(.DIV(DIV)) u_eng (
        .clk(clk), .rst(rst), .en(eng_en),
        .cpol(ctrl_q.cpol), .cpha(ctrl_q.cpha), .lsb_first(ctrl_q.lsb_first),
        .loop_en(loop_en), .tx_empty(tx_empty), .tx_data(tx_head),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_word),
        .miso(miso), .sck(sck), .mosi(mosi), .busy(eng_busy)
    );

    // per-line select: manual follows the register, automatic gates it with the engine
    for (genvar i = 0; i < NSS; i++) begin : g_ss
        assign ss_n[i] = !ss_live ? 1'b1 :
                         ctrl_q.manual_ss ? sel_q[i] :
                         (eng_busy ? sel_q[i] : 1'b1);
    end

    always_comb begin
        reg_rdata = '0;
        unique case (addr_e)
            REG_CTRL: reg_rdata[CTRL_W-1:0] = ctrl_q;
            REG_DATA: begin
                reg_rdata[WORD_W]     = !rx_empty;
                reg_rdata[WORD_W-1:0] = rx_empty ? '0 : rx_head;
            end
            REG_SEL:  reg_rdata[NSS-1:0] = sel_q;
            default:  reg_rdata = '0;
        endcase
    end

    AST_TX_STROBE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.tx_flush && !wr_ctrl) |=> !ctrl_q.tx_flush); // R9

    AST_RX_STROBE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.rx_flush && !wr_ctrl) |=> !ctrl_q.rx_flush); // R9

    AST_NO_START_INHIBITED: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.inhibit && !eng_busy) |=> !eng_busy); // R6

endmodule

// File: tb/spi_cfg_master_test.sv
`timescale 1ns/1ps
module spi_cfg_master_test;
    localparam int DIV = 4;
    localparam int NSS = 4;
    localparam int HALF = DIV / 2;
    localparam logic [31:0] B_LOOP = 32'h001, B_SPE = 32'h002, B_MST = 32'h004,
        B_CPOL = 32'h008, B_CPHA = 32'h010, B_TXR = 32'h020, B_RXR = 32'h040,
        B_MAN = 32'h080, B_INH = 32'h100, B_LSB = 32'h200;

    logic clk = 0, rst = 1, reg_we = 0, reg_re = 0, miso = 0;
    logic [1:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic sck, mosi;
    logic [NSS-1:0] ss_n;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int widx = 0, k = 0, rises = 0, falls = 0, t_fall = 0, t_e0 = 0, t_e2 = 0;
    logic s_cpha = 0, s_lsb = 0;
    logic [7:0] sl_out [16];
    logic [7:0] cap [16];
    logic [7:0] txb [16];
    logic [31:0] rdv;
    bit done = 0;

    spi_cfg_master #(.DIV(DIV), .NSS(NSS), .FIFO_DEPTH(4)) uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck(sck), .mosi(mosi),
        .miso(miso), .ss_n(ss_n));

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc = cyc + 1;

    function automatic int bitpos(input int p, input logic lsb);
        return lsb ? p : 7 - p;
    endfunction

    function automatic logic [31:0] mode_word(input logic cpol, input logic cpha,
                                              input logic lsb);
        return B_SPE | B_MST | (cpol ? B_CPOL : 0) | (cpha ? B_CPHA : 0) | (lsb ? B_LSB : 0);
    endfunction

    function automatic logic [31:0] rx_expect(input logic [7:0] w);
        return {23'd0, 1'b1, w};
    endfunction

    // bench slave model
    always @(negedge ss_n[0]) begin
        falls = falls + 1;
        k = 0;
        if (!s_cpha && widx < 16) miso = sl_out[widx][bitpos(0, s_lsb)];
        #1 if (widx == 0) t_fall = cyc;
    end
    always @(posedge ss_n[0]) rises = rises + 1;

    always @(sck) begin
        #1;
        if (ss_n[0] === 1'b0 && widx < 16) begin
            if (widx == 0 && k == 0) t_e0 = cyc;
            if (widx == 0 && k == 2) t_e2 = cyc;
            if (s_cpha ? (k % 2 == 1) : (k % 2 == 0))
                cap[widx][bitpos(k / 2, s_lsb)] = mosi;
            if (s_cpha && (k % 2 == 0))
                miso = sl_out[widx][bitpos(k / 2, s_lsb)];
            if (!s_cpha && (k % 2 == 1) && ((k + 1) / 2 < 8))
                miso = sl_out[widx][bitpos((k + 1) / 2, s_lsb)];
            k = k + 1;
            if (k == 16) begin
                k = 0;
                widx = widx + 1;
                if (!s_cpha && widx < 16) miso = sl_out[widx][bitpos(0, s_lsb)];
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_re = 1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_re = 0;
    endtask

    task automatic reset_slave();
        widx = 0; k = 0; rises = 0; falls = 0;
        for (int i = 0; i < 16; i++) cap[i] = 8'h00;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // one burst of n words in the given mode, checked against the slave model
    task automatic burst(input int n, input logic cpol, input logic cpha, input logic lsb);
        wr(2'd0, mode_word(cpol, cpha, lsb));
        s_cpha = cpha; s_lsb = lsb;
        reset_slave();
        for (int i = 0; i < n; i++) wr(2'd1, {24'd0, txb[i]});
        repeat (40 * n + 20) @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            check("R4 R5 mosi word", {24'd0, cap[i]}, {24'd0, txb[i]});
            rd(2'd1, rdv);
            check("R4 R5 R12 rx word", rdv, rx_expect(sl_out[i]));
        end
        check("R8 single rise per burst", rises, 1);
        check("R8 lead time", t_e0 - t_fall, HALF);
        check("R11 sck period", t_e2 - t_e0, DIV);
        check("R3 idle sck", {31'd0, sck}, {31'd0, cpol});
        check("R8 ss released", {28'd0, ss_n}, 32'hF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        for (int i = 0; i < 16; i++) begin sl_out[i] = 0; cap[i] = 0; txb[i] = 0; end
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 0;

        // reset state
        rd(2'd0, rdv);
        check("R2 ctrl reset", rdv, 32'h180);
        check("R2 ss_n reset", {28'd0, ss_n}, 32'hF);
        check("R2 sck reset", {31'd0, sck}, 0);
        rd(2'd1, rdv);
        check("R2 R12 rx empty", rdv, 0);

        // reserved bits
        wr(2'd0, 32'hFFFF_FC00 | B_INH | B_MAN);
        rd(2'd0, rdv);
        check("R1 reserved ignored", rdv, 32'h180);
        wr(2'd0, B_LOOP | B_CPHA | B_LSB | B_INH);
        rd(2'd0, rdv);
        check("R1 field readback", rdv, B_LOOP | B_CPHA | B_LSB | B_INH);

        // inhibit blocks start
        wr(2'd2, 32'hE);
        wr(2'd0, B_SPE | B_MST | B_INH);
        reset_slave();
        wr(2'd1, 32'hA5);
        repeat (60) @(posedge clk);
        @(negedge clk);
        check("R6 no start ss", falls, 0);
        rd(2'd1, rdv);
        check("R6 no rx while inhibited", rdv, 0);
        wr(2'd0, B_SPE | B_MST | B_LOOP);
        repeat (60) @(posedge clk);
        rd(2'd1, rdv);
        check("R6 R10 R12 runs after release", rdv, rx_expect(8'hA5));

        // directed LSB-first corner
        txb[0] = 8'h01; sl_out[0] = 8'h80;
        burst(1, 1'b0, 1'b0, 1'b1);

        // random modes and words
        for (int it = 0; it < 10; it++) begin
            int n;
            logic cpol, cpha, lsb;
            n = 1 + int'($urandom_range(2));
            cpol = $urandom_range(1); cpha = $urandom_range(1); lsb = $urandom_range(1);
            for (int i = 0; i < n; i++) begin
                txb[i] = 8'($urandom); sl_out[i] = 8'($urandom);
            end
            burst(n, cpol, cpha, lsb);
        end

        // loopback ignores miso
        for (int i = 0; i < 3; i++) begin txb[i] = 8'($urandom); sl_out[i] = ~txb[i]; end
        wr(2'd0, B_SPE | B_MST | B_LOOP | B_LSB | B_CPHA);
        s_cpha = 1; s_lsb = 1; reset_slave();
        for (int i = 0; i < 3; i++) wr(2'd1, {24'd0, txb[i]});
        repeat (150) @(posedge clk);
        for (int i = 0; i < 3; i++) begin
            rd(2'd1, rdv);
            check("R10 loopback word", rdv, rx_expect(txb[i]));
        end

        // manual select
        wr(2'd0, B_SPE | B_MST | B_MAN);
        wr(2'd2, 32'hA);
        @(negedge clk);
        check("R7 manual follows reg", {28'd0, ss_n}, 32'hA);
        wr(2'd0, B_MST | B_MAN);
        @(negedge clk);
        check("R7 disabled all high", {28'd0, ss_n}, 32'hF);
        wr(2'd2, 32'hE);

        // transmit flush
        wr(2'd0, B_SPE | B_MST | B_INH);
        wr(2'd1, 32'h11);
        wr(2'd1, 32'h22);
        wr(2'd0, B_SPE | B_MST | B_INH | B_TXR);
        rd(2'd0, rdv);
        check("R9 tx strobe self clears", rdv, B_SPE | B_MST | B_INH);
        reset_slave();
        wr(2'd0, B_SPE | B_MST | B_LOOP);
        repeat (80) @(posedge clk);
        check("R9 tx flushed no transfer", falls, 0);
        rd(2'd1, rdv);
        check("R9 tx flushed no rx", rdv, 0);

        // receive flush
        wr(2'd1, 32'h33);
        wr(2'd1, 32'h44);
        repeat (100) @(posedge clk);
        wr(2'd0, B_SPE | B_MST | B_LOOP | B_RXR);
        rd(2'd0, rdv);
        check("R9 rx strobe self clears", rdv, B_SPE | B_MST | B_LOOP);
        rd(2'd1, rdv);
        check("R9 rx flushed", rdv, 0);

        // inhibit mid-transfer
        wr(2'd0, B_SPE | B_MST);
        s_cpha = 0; s_lsb = 0; reset_slave();
        wr(2'd1, 32'h5A);
        repeat (10) @(posedge clk);
        wr(2'd0, B_SPE | B_MST | B_INH);
        @(negedge clk);
        check("R6 abort ss high", {28'd0, ss_n}, 32'hF);
        check("R6 abort sck idle", {31'd0, sck}, 0);
        repeat (50) @(posedge clk);
        rd(2'd1, rdv);
        check("R6 aborted word dropped", rdv, 0);

        done = 1;
        finish_run();
    end
endmodule